// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches a small set of external interrupt pins (two by default) and turns their activity into interrupt requests for a processor. Each pin has its own two-bit sense mode. The four modes are: low level, any change, falling edge and rising edge. Every pin passes through a synchronizer. Edges are found by comparing the newest synchronized sample with the sample one cycle older.

Software reaches four registers through a simple write port and a combinational read port: a sense control register, a mask register, a flag register and a status register that holds the global enable. In the three edge modes a qualifying event latches a flag. The flag stays set until the processor acknowledges the interrupt or software writes a 1 to that flag bit. In low-level mode no flag is latched; the request simply follows the synchronized pin. A request reaches the processor only when both its mask bit and the global enable are set.

A per-pin direction input exists only for information, and it never changes detection. Vector dispatch and context saving belong to the processor and are not part of this block.

Top module: `ext_irq_sense`

## Requirements
- R1: Register address 0 is the sense control register. Bits 1:0 hold the mode of input 0 and bits 3:2 hold the mode of input 1. Reads return the written field bits, and bits above the fields read as 0.
- R2: Sense code 00 (low level) latches no flag. The request for that input is high while the synchronized pin is low and the request is enabled. It rises 2 cycles after the pin falls and drops 2 cycles after the pin rises.
- R3: Sense code 01 sets the input's flag (address 2, bit 0 for input 0, bit 1 for input 1) on either edge of the pin, 3 cycles after the pin changes. A pin that holds its level sets nothing.
- R4: Sense code 10 sets the flag on a falling edge only.
- R5: Sense code 11 sets the flag on a rising edge only. The flag and the request are still 0 two cycles after the edge and are 1 three cycles after it.
- R6: Mask register (address 1) bit n enables the request of input n. A flag is latched whatever the mask holds, but the request stays 0 while the mask bit is 0.
- R7: Bit 7 of the status register (address 3) is the global enable. While it is 0, no request is raised, whatever the mask and flags hold. Status bits other than bit 7 read as 0.
- R8: A one-cycle pulse on `ack_i[n]` clears flag n and no other flag.
- R9: Writing 1 to a flag bit clears it and writing 0 leaves it unchanged. When a clear and a new event for the same input fall in the same cycle, the flag stays set.
- R10: `pin_dir_i` has no effect on detection, flags or requests.
- R11: After reset all four registers read 0 and all request outputs are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | N_IN | Asynchronous external interrupt pins |
| pin_dir_i | input | N_IN | Pin direction, informational only, ignored |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 2 | Register read address |
| rd_data_o | output | 8 | Combinational read data |
| ack_i | input | N_IN | Per-input interrupt acknowledge, clears the flag |
| irq_req_o | output | N_IN | Per-input gated interrupt request |
| irq_any_o | output | 1 | OR of all requests |

## Verification
Results arrive at different delays after a pin change. An edge-mode flag, and any request it raises, appears after the third rising clock edge. A low-level request appears or drops after the second. Register writes and acknowledges take effect at the next edge. The bench drives every input just after a falling edge and counts falling edges before it samples, so each check lands exactly on the cycle its result is due. For the two main delays it also checks one cycle early and sees the old value there. The test where a set and a clear collide places the flag write on the one edge where the synchronized edge is visible.

// File: rtl/eis_pkg.sv
package eis_pkg;

    localparam int REG_W  = 8;
    localparam int ADDR_W = 2;
    localparam int GIE_BIT = 7;

    localparam logic [ADDR_W-1:0] ADDR_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MASK = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 2'd3;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    typedef struct packed {
        logic cur;
        logic prev;
    } pin_view_t;

    function automatic logic edge_hit(sense_e mode, pin_view_t v);
        case (mode)
            SENSE_ANY:  return v.cur ^ v.prev;
            SENSE_FALL: return v.prev & ~v.cur;
            SENSE_RISE: return ~v.prev & v.cur;
            default:    return 1'b0;
        endcase
    endfunction

    function automatic logic level_hit(sense_e mode, pin_view_t v);
        return (mode == SENSE_LOW) && !v.cur;
    endfunction

endpackage

// File: rtl/eis_sync.sv
module eis_sync
    import eis_pkg::*;
#(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    output pin_view_t view_o
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= {STAGES{RESET_VAL}};
            prev_q  <= RESET_VAL;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], pin_i};
            prev_q  <= chain_q[STAGES-1];
        end
    end

    assign view_o.cur  = chain_q[STAGES-1];
    assign view_o.prev = prev_q;

endmodule

// File: rtl/eis_detect.sv
module eis_detect
    import eis_pkg::*;
(
    input  sense_e    mode_i,
    input  pin_view_t view_i,
    output logic      event_o,
    output logic      level_o
);

    assign event_o = edge_hit(mode_i, view_i);
    assign level_o = level_hit(mode_i, view_i);

endmodule

// File: rtl/eis_regs.sv
module eis_regs
    import eis_pkg::*;
#(
    parameter int N_IN = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en_i,
    input  logic [ADDR_W-1:0]  wr_addr_i,
    input  logic [REG_W-1:0]   wr_data_i,
    input  logic [ADDR_W-1:0]  rd_addr_i,
    output logic [REG_W-1:0]   rd_data_o,
    input  logic [N_IN-1:0]    set_i,
    input  logic [N_IN-1:0]    ack_i,
    output logic [2*N_IN-1:0]  ctrl_o,
    output logic [N_IN-1:0]    mask_o,
    output logic [N_IN-1:0]    flag_o,
    output logic               gie_o
);

    localparam int CTRL_W = 2 * N_IN;

    logic [CTRL_W-1:0] ctrl_q;
    logic [N_IN-1:0]   mask_q;
    logic [N_IN-1:0]   flag_q;
    logic              gie_q;
    logic [N_IN-1:0]   clr_w;
    logic              unused_wdata;

    assign unused_wdata = ^wr_data_i;
    assign clr_w = (wr_en_i && wr_addr_i == ADDR_FLAG) ? wr_data_i[N_IN-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mask_q <= '0;
            flag_q <= '0;
            gie_q  <= 1'b0;
        end else begin
            if (wr_en_i && wr_addr_i == ADDR_CTRL) ctrl_q <= wr_data_i[CTRL_W-1:0];
            if (wr_en_i && wr_addr_i == ADDR_MASK) mask_q <= wr_data_i[N_IN-1:0];
            if (wr_en_i && wr_addr_i == ADDR_STAT) gie_q  <= wr_data_i[GIE_BIT];
            flag_q <= set_i | (flag_q & ~(clr_w | ack_i));
        end
    end

    always_comb begin
        rd_data_o = '0;
        case (rd_addr_i)
            ADDR_CTRL: rd_data_o[CTRL_W-1:0] = ctrl_q;
            ADDR_MASK: rd_data_o[N_IN-1:0]   = mask_q;
            ADDR_FLAG: rd_data_o[N_IN-1:0]   = flag_q;
            ADDR_STAT: rd_data_o[GIE_BIT]    = gie_q;
            default:   rd_data_o = '0;
        endcase
    end

    assign ctrl_o = ctrl_q;
    assign mask_o = mask_q;
    assign flag_o = flag_q;
    assign gie_o  = gie_q;

    for (genvar i = 0; i < N_IN; i++) begin : g_flag_chk
        assert_set_wins_R9: assert property (@(posedge clk) disable iff (rst)
            set_i[i] |=> flag_q[i]);
        assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
            (ack_i[i] && !set_i[i]) |=> !flag_q[i]);
        assert_flag_holds_R9: assert property (@(posedge clk) disable iff (rst)
            (flag_q[i] && !clr_w[i] && !ack_i[i]) |=> flag_q[i]);
    end

endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
    import eis_pkg::*;
#(
    parameter int N_IN        = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [N_IN-1:0]   pin_i,
    input  logic [N_IN-1:0]   pin_dir_i,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [REG_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [REG_W-1:0]  rd_data_o,
    input  logic [N_IN-1:0]   ack_i,
    output logic [N_IN-1:0]   irq_req_o,
    output logic              irq_any_o
);

    pin_view_t           view [N_IN];
    logic [N_IN-1:0]     evt;
    logic [N_IN-1:0]     lvl;
    logic [N_IN-1:0]     mask;
    logic [N_IN-1:0]     flag;
    logic [2*N_IN-1:0]   ctrl;
    logic                gie;
    logic                unused_dir;

    assign unused_dir = ^pin_dir_i;

    eis_regs #(.N_IN(N_IN)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .set_i     (evt),
        .ack_i     (ack_i),
        .ctrl_o    (ctrl),
        .mask_o    (mask),
        .flag_o    (flag),
        .gie_o     (gie)
    );

    for (genvar i = 0; i < N_IN; i++) begin : g_in
        eis_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
            .clk    (clk),
            .rst    (rst),
            .pin_i  (pin_i[i]),
            .view_o (view[i])
        );

        eis_detect u_det (
            .mode_i  (sense_e'(ctrl[2*i +: 2])),
            .view_i  (view[i]),
            .event_o (evt[i]),
            .level_o (lvl[i])
        );

        assign irq_req_o[i] = gie & mask[i] & (flag[i] | lvl[i]);

        assert_mask_gate_R6: assert property (@(posedge clk) disable iff (rst)
            irq_req_o[i] |-> mask[i]);
        assert_gie_gate_R7: assert property (@(posedge clk) disable iff (rst)
            irq_req_o[i] |-> gie);
        assert_level_no_flag_R2: assert property (@(posedge clk) disable iff (rst)
            $rose(flag[i]) |-> ($past(ctrl[2*i +: 2]) != SENSE_LOW));
        assert_rise_origin_R5: assert property (@(posedge clk) disable iff (rst)
            ($rose(flag[i]) && $past(ctrl[2*i +: 2]) == SENSE_RISE)
                |-> $past(view[i].cur && !view[i].prev));
    end

    assign irq_any_o = |irq_req_o;

endmodule

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb;
    import eis_pkg::*;

    localparam int N_IN  = 2;
    localparam int N_VEC = 14;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [N_IN-1:0]   pin_i = '1;
    logic [N_IN-1:0]   pin_dir_i = '0;
    logic              wr_en_i = 1'b0;
    logic [ADDR_W-1:0] wr_addr_i = '0;
    logic [REG_W-1:0]  wr_data_i = '0;
    logic [ADDR_W-1:0] rd_addr_i = '0;
    logic [REG_W-1:0]  rd_data_o;
    logic [N_IN-1:0]   ack_i = '0;
    logic [N_IN-1:0]   irq_req_o;
    logic              irq_any_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    ext_irq_sense #(.N_IN(N_IN)) u_dut (
        .clk(clk), .rst(rst), .pin_i(pin_i), .pin_dir_i(pin_dir_i),
        .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .ack_i(ack_i),
        .irq_req_o(irq_req_o), .irq_any_o(irq_any_o)
    );

    // {req[3:0], ch, sense[1:0], mask, gie, dir, p0, p1, exp_flag, exp_req}
    localparam logic [13:0] VEC [N_VEC] = '{
        {4'd5,  1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R5 rise seen
        {4'd5,  1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R5 fall ignored
        {4'd4,  1'b0, 2'b10, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R4 fall seen
        {4'd4,  1'b0, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R4 rise ignored
        {4'd3,  1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1}, // R3 up
        {4'd3,  1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R3 down
        {4'd3,  1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0}, // R3 steady
        {4'd6,  1'b0, 2'b11, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0}, // R6 masked
        {4'd7,  1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0}, // R7 gie off
        {4'd10, 1'b0, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1}, // R10 output dir
        {4'd2,  1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1}, // R2 low held
        {4'd2,  1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0}, // R2 released
        {4'd6,  1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R6 level masked
        {4'd7,  1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}  // R7 level gie off
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [REG_W-1:0] d);
        wr_en_i   = 1'b1;
        wr_addr_i = a;
        wr_data_i = d;
        tick(1);
        wr_en_i   = 1'b0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [REG_W-1:0] d);
        rd_addr_i = a;
        #1;
        d = rd_data_o;
    endtask

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    task automatic setup(input logic [7:0] ctrl, input logic [7:0] msk,
                         input logic [7:0] stat, input logic [N_IN-1:0] pins);
        pin_i = pins;
        wr(ADDR_CTRL, ctrl);
        wr(ADDR_MASK, msk);
        wr(ADDR_STAT, stat);
        tick(4);
        wr(ADDR_FLAG, 8'hFF);
    endtask

    initial begin
        #(4 * 150000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [7:0] d;

        // R11 reset state
        tick(3);
        rst = 1'b0;
        tick(1);
        rd(ADDR_CTRL, d); check("R11 ctrl", d, 8'h00);
        rd(ADDR_MASK, d); check("R11 mask", d, 8'h00);
        rd(ADDR_FLAG, d); check("R11 flag", d, 8'h00);
        rd(ADDR_STAT, d); check("R11 stat", d, 8'h00);
        check("R11 req", {6'b0, irq_req_o}, 8'h00);

        // R1 field readback, R7 status bits
        tick(1);
        wr(ADDR_CTRL, 8'hFB); rd(ADDR_CTRL, d); check("R1 ctrl readback", d, 8'h0B);
        tick(1);
        wr(ADDR_MASK, 8'hFF); rd(ADDR_MASK, d); check("R6 mask readback", d, 8'h03);
        tick(1);
        wr(ADDR_STAT, 8'h7F); rd(ADDR_STAT, d); check("R7 stat low bits", d, 8'h00);
        tick(1);

        // Table walk
        for (int k = 0; k < N_VEC; k++) begin
            logic [13:0] v;
            int ch;
            string tag;
            v  = VEC[k];
            ch = int'(v[9]);
            tag = $sformatf("R%0d vec%0d", v[13:10], k);
            pin_dir_i = {N_IN{v[4]}};
            pin_i = '1;
            pin_i[ch] = v[3];
            setup({4'b0, v[8:7]} << (2 * ch), {7'b0, v[6]} << ch, {v[5], 7'b0}, pin_i);
            pin_i[ch] = v[2];
            tick(3);
            rd(ADDR_FLAG, d);
            check({tag, " flag"}, {7'b0, d[ch]}, {7'b0, v[1]});
            check({tag, " req"}, {7'b0, irq_req_o[ch]}, {7'b0, v[0]});
            check({tag, " any"}, {7'b0, irq_any_o}, {7'b0, v[0]});
            tick(1);
        end
        pin_dir_i = '0;

        // R5 latency: not yet at 2 edges, present at 3
        setup(8'h03, 8'h01, 8'h80, 2'b10);
        pin_i[0] = 1'b1;
        tick(2);
        rd(ADDR_FLAG, d); check("R5 flag early", d, 8'h00);
        check("R5 req early", {6'b0, irq_req_o}, 8'h00);
        tick(1);
        rd(ADDR_FLAG, d); check("R5 flag due", d, 8'h01);
        check("R5 req due", {6'b0, irq_req_o}, 8'h01);

        // R2 level latency both directions
        setup(8'h00, 8'h01, 8'h80, 2'b11);
        pin_i[0] = 1'b0;
        tick(1); check("R2 assert early", {6'b0, irq_req_o}, 8'h00);
        tick(1); check("R2 assert due", {6'b0, irq_req_o}, 8'h01);
        pin_i[0] = 1'b1;
        tick(1); check("R2 release early", {6'b0, irq_req_o}, 8'h01);
        tick(1); check("R2 release due", {6'b0, irq_req_o}, 8'h00);

        // R8 ack clears only its own flag
        setup(8'h05, 8'h03, 8'h80, 2'b11);
        pin_i = 2'b00;
        tick(3);
        rd(ADDR_FLAG, d); check("R8 both set", d, 8'h03);
        ack_i = 2'b01;
        tick(1);
        ack_i = 2'b00;
        rd(ADDR_FLAG, d); check("R8 ack0 flag", d, 8'h02);
        check("R8 ack0 req", {6'b0, irq_req_o}, 8'h02);

        // R9 write-one-to-clear
        wr(ADDR_FLAG, 8'h00);
        rd(ADDR_FLAG, d); check("R9 write zero", d, 8'h02);
        wr(ADDR_FLAG, 8'h02);
        rd(ADDR_FLAG, d); check("R9 write one", d, 8'h00);
        // R9 set wins over clear in same cycle
        pin_i[0] = 1'b1;
        tick(2);
        wr(ADDR_FLAG, 8'h01);
        rd(ADDR_FLAG, d); check("R9 set beats clear", d, 8'h01);

        summary();
        $finish;
    end

endmodule